// File: doc/BRIEF.md
# Fixed-Point Perspective Projection Unit

This block maps one vertex, or three in a row, from object space onto the screen. Each signed 16-bit vertex is multiplied by a signed 16-bit 3x3 rotation matrix, scaled down by 12 fractional bits and offset by a 32-bit translation. The depth term is divided into a projection distance to get a 17-bit perspective factor. That factor scales the first two rotated components, a screen offset is added, and the factor also drives a linear depth-cue term.

A host puts the matrix, translation, offsets, distance and vertices on register-style inputs and holds them steady. It then pulses `start_i` with the mode selected on `triple_i` and waits for `done_o`. The results sit in output registers: four accumulator words, four clamped intermediates, a three-deep screen-point history and a four-deep depth history. These registers change only in the cycle where `done_o` is high.

Top module: `persp_proj_unit`

## Requirements
- R1: For each row r (0..2), the accumulator output is trans[r] + ((rot[r][0]*x + rot[r][1]*y + rot[r][2]*z) >>> 12), wrapped to 32 bits. Packing: rot element (r,c) is at bits [(3r+c)*16 +: 16] of `rot_i`; vertex v component c (x=0, y=1, z=2) is at bits [(3v+c)*16 +: 16] of `vtx_i`; trans[r] is at bits [r*32 +: 32] of `trans_i`.
- R2: The outputs ir1..ir3 are accumulators 1..3 saturated to -32768..32767.
- R3: The depth of a vertex is accumulator 3 clamped to 0..65535. In single mode, sz0..sz2 take the old sz1..sz3 and sz3 takes the new depth.
- R4: The factor q equals 0x1FFFF when distance >= 2*depth (unsigned compare, which also covers depth 0). Otherwise q = (distance*65536)/depth, truncated.
- R5: The screen x is (ofx + ir1*q) >>> 16 and the screen y is (ofy + ir2*q) >>> 16, both computed at full width and each saturated to -1024..1023. A screen point word holds x sign-extended in bits 15:0 and y sign-extended in bits 31:16.
- R6: In single mode, sxy0 and sxy1 take the old sxy1 and sxy2, and sxy2 takes the new point.
- R7: mac0 = dqb + dqa*q, wrapped to 32 bits, using the last vertex's q. ir0 is mac0 >>> 12 clamped to 0..4096.
- R8: In triple mode, vertices 0, 1 and 2 are handled in order. sz0 takes the old sz3, sz1..sz3 take the depths of vertices 0..2, and sxy0..sxy2 take their screen points. mac1..3 and ir1..3 come from vertex 2.
- R9: After a start pulse in idle, `busy_o` is high from the next cycle. `done_o` is a one-cycle pulse with `busy_o` low. All result outputs change only in the `done_o` cycle.
- R10: A start pulse while busy is ignored. It launches no second operation and causes no extra history shift.
- R11: After reset, every result output is zero and `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| triple_i | input | 1 | 1: three vertices, 0: vertex 0 only |
| vtx_i | input | 144 | Three packed signed vertices |
| rot_i | input | 144 | Packed signed 3x3 matrix |
| trans_i | input | 96 | Packed signed translation |
| ofx_i | input | 32 | Signed screen x offset, 16.16 |
| ofy_i | input | 32 | Signed screen y offset, 16.16 |
| hdist_i | input | 16 | Unsigned projection distance |
| dqa_i | input | 16 | Signed depth-cue slope |
| dqb_i | input | 32 | Signed depth-cue base |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mac0_o | output | 32 | Depth-cue accumulator |
| mac1_o | output | 32 | Row 0 accumulator |
| mac2_o | output | 32 | Row 1 accumulator |
| mac3_o | output | 32 | Row 2 accumulator |
| ir0_o | output | 16 | Clamped depth-cue value |
| ir1_o | output | 16 | Saturated row 0 |
| ir2_o | output | 16 | Saturated row 1 |
| ir3_o | output | 16 | Saturated row 2 |
| sxy0_o | output | 32 | Oldest screen point |
| sxy1_o | output | 32 | Middle screen point |
| sxy2_o | output | 32 | Newest screen point |
| sz0_o | output | 16 | Oldest depth |
| sz1_o | output | 16 | Depth history 1 |
| sz2_o | output | 16 | Depth history 2 |
| sz3_o | output | 16 | Newest depth |

## Verification
The main sweep tries three matrices with eight vertex component values and four distances, alternating between single and triple mode.
- An identity matrix isolates the divider and offset path.
- A mixed-sign matrix with a small translation exercises the shift and rounding of each row.
- A full-scale alternating matrix with huge translations drives accumulator wrap, saturation of the intermediates, negative and over-range depth clamps, and screen saturation.

Directed runs set a slope of 1 and a base of 0, so mac0 shows q directly. They probe distance exactly at twice the depth, one below it, depth zero and a maximum depth. A final run pulses start mid-operation to show that the history does not shift a second time.

// File: rtl/ppu_pkg.sv
package ppu_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XFORM,
        ST_WAIT,
        ST_PROJ,
        ST_FIN
    } ppu_state_e;
endpackage

// File: rtl/ppu_xform.sv
module ppu_xform #(
    parameter int VW   = 16,
    parameter int MW   = 32,
    parameter int FRAC = 12,
    parameter int DIM  = 3
) (
    input  logic [DIM*DIM*VW-1:0] rot_i,
    input  logic [DIM*VW-1:0]     vec_i,
    input  logic [DIM*MW-1:0]     trans_i,
    output logic [DIM*MW-1:0]     mac_o
);
    localparam int PW = 2*VW + $clog2(DIM) + 1;
    localparam int SW = PW - FRAC;

    for (genvar r = 0; r < DIM; r++) begin : g_row
        logic signed [PW-1:0] term [DIM];
        logic signed [PW-1:0] acc;
        logic signed [SW-1:0] scaled;

        for (genvar c = 0; c < DIM; c++) begin : g_col
            logic signed [VW-1:0]   m_el;
            logic signed [VW-1:0]   v_el;
            logic signed [2*VW-1:0] prod;
            assign m_el    = rot_i[(r*DIM+c)*VW +: VW];
            assign v_el    = vec_i[c*VW +: VW];
            assign prod    = m_el * v_el;
            assign term[c] = {{(PW-2*VW){prod[2*VW-1]}}, prod};
        end

        always_comb begin
            acc = '0;
            for (int c = 0; c < DIM; c++) begin
                acc = acc + term[c];
            end
        end

        assign scaled = SW'(acc >>> FRAC);
        assign mac_o[r*MW +: MW] = trans_i[r*MW +: MW] + {{(MW-SW){scaled[SW-1]}}, scaled};
    end
endmodule

// File: rtl/ppu_divider.sv
module ppu_divider #(
    parameter int NW = 16,
    parameter int QW = NW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [NW-1:0] num_i,
    input  logic [NW-1:0] den_i,
    output logic          done_o,
    output logic [QW-1:0] quo_o
);
    localparam int CW = $clog2(QW + 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [NW-1:0] rem;
        logic [NW-1:0] den;
        logic [QW-1:0] feed;
        logic [QW-1:0] quo;
    } div_regs_t;

    div_regs_t r_q, r_d;
    logic          ovf;
    logic [NW:0]   trial;
    logic          fits;
    logic [NW-1:0] diff;

    assign ovf   = {1'b0, num_i} >= {den_i, 1'b0};
    assign trial = {r_q.rem, r_q.feed[QW-1]};
    assign fits  = trial >= {1'b0, r_q.den};
    assign diff  = trial[NW-1:0] - r_q.den;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (start_i) begin
            r_d.den = den_i;
            if (ovf) begin
                r_d.quo  = '1;
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
            end else begin
                r_d.quo  = '0;
                r_d.busy = 1'b1;
                r_d.cnt  = CW'(QW);
                r_d.rem  = {1'b0, num_i[NW-1:1]};
                r_d.feed = {num_i[0], {(QW-1){1'b0}}};
            end
        end else if (r_q.busy) begin
            r_d.rem  = fits ? diff : trial[NW-1:0];
            r_d.quo  = {r_q.quo[QW-2:0], fits};
            r_d.feed = {r_q.feed[QW-2:0], 1'b0};
            r_d.cnt  = r_q.cnt - 1'b1;
            if (r_q.cnt == CW'(1)) begin
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done_o = r_q.done;
    assign quo_o  = r_q.quo;

    // R4: the running remainder of a restoring step always stays below the divisor
    assert_rem_below_den_R4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.busy |-> (r_q.rem < r_q.den));

    // R4: an overflowing request answers on the next cycle with the saturated factor
    assert_ovf_saturates_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && ovf) |=> (done_o && quo_o == '1));
endmodule

// File: rtl/persp_proj_unit.sv
module persp_proj_unit
    import ppu_pkg::*;
#(
    parameter int VW   = 16,
    parameter int MW   = 32,
    parameter int FRAC = 12,
    parameter int SCR  = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                triple_i,
    input  logic [3*3*VW-1:0]   vtx_i,
    input  logic [3*3*VW-1:0]   rot_i,
    input  logic [3*MW-1:0]     trans_i,
    input  logic [MW-1:0]       ofx_i,
    input  logic [MW-1:0]       ofy_i,
    input  logic [VW-1:0]       hdist_i,
    input  logic [VW-1:0]       dqa_i,
    input  logic [MW-1:0]       dqb_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [MW-1:0]       mac0_o,
    output logic [MW-1:0]       mac1_o,
    output logic [MW-1:0]       mac2_o,
    output logic [MW-1:0]       mac3_o,
    output logic [VW-1:0]       ir0_o,
    output logic [VW-1:0]       ir1_o,
    output logic [VW-1:0]       ir2_o,
    output logic [VW-1:0]       ir3_o,
    output logic [2*VW-1:0]     sxy0_o,
    output logic [2*VW-1:0]     sxy1_o,
    output logic [2*VW-1:0]     sxy2_o,
    output logic [VW-1:0]       sz0_o,
    output logic [VW-1:0]       sz1_o,
    output logic [VW-1:0]       sz2_o,
    output logic [VW-1:0]       sz3_o
);
    localparam int DIM = 3;
    localparam int QW  = VW + 1;
    localparam int VSL = DIM * VW;
    localparam int PJW = ((VW + QW + 1) > MW ? (VW + QW + 1) : MW) + 1;

    localparam logic signed [MW-1:0]  IR_MAX  = {{(MW-VW+1){1'b0}}, {(VW-1){1'b1}}};
    localparam logic signed [MW-1:0]  IR_MIN  = {{(MW-VW+1){1'b1}}, {(VW-1){1'b0}}};
    localparam logic signed [MW-1:0]  Z_MAX   = {{(MW-VW){1'b0}}, {VW{1'b1}}};
    localparam logic signed [MW-1:0]  IR0_MAX = {{(MW-FRAC-1){1'b0}}, 1'b1, {FRAC{1'b0}}};
    localparam logic signed [PJW-1:0] SX_MAX  = {{(PJW-SCR+1){1'b0}}, {(SCR-1){1'b1}}};
    localparam logic signed [PJW-1:0] SX_MIN  = {{(PJW-SCR+1){1'b1}}, {(SCR-1){1'b0}}};

    typedef struct packed {
        ppu_state_e                st;
        logic                      busy;
        logic                      done;
        logic                      trip;
        logic [1:0]                vidx;
        logic [DIM-1:0][MW-1:0]    wmac;
        logic [DIM-1:0][VW-1:0]    wir;
        logic [DIM-1:0][VW-1:0]    wz;
        logic [DIM-1:0][2*VW-1:0]  wxy;
        logic [QW-1:0]             wq;
        logic [MW-1:0]             mac0;
        logic [DIM-1:0][MW-1:0]    mac;
        logic [VW-1:0]             ir0;
        logic [DIM-1:0][VW-1:0]    ir;
        logic [DIM:0][VW-1:0]      sz;
        logic [DIM-1:0][2*VW-1:0]  sxy;
    } ppu_regs_t;

    ppu_regs_t r_q, r_d;

    function automatic logic [VW-1:0] sat_ir(input logic signed [MW-1:0] m);
        if (m > IR_MAX)      return VW'(IR_MAX);
        else if (m < IR_MIN) return VW'(IR_MIN);
        else                 return VW'(m);
    endfunction

    function automatic logic [VW-1:0] clamp_z(input logic signed [MW-1:0] m);
        if (m < 0)          return '0;
        else if (m > Z_MAX) return VW'(Z_MAX);
        else                return VW'(m);
    endfunction

    function automatic logic [VW-1:0] project(input logic signed [MW-1:0] off,
                                              input logic signed [VW-1:0] irv,
                                              input logic [QW-1:0]        qv);
        logic signed [PJW-1:0] prod;
        logic signed [PJW-1:0] sum;
        logic signed [PJW-1:0] shd;
        prod = PJW'(irv) * PJW'(signed'({1'b0, qv}));
        sum  = prod + PJW'(off);
        shd  = sum >>> VW;
        if (shd > SX_MAX)      return VW'(SX_MAX);
        else if (shd < SX_MIN) return VW'(SX_MIN);
        else                   return VW'(shd);
    endfunction

    function automatic logic [MW-1:0] cue(input logic signed [VW-1:0] slope,
                                          input logic signed [MW-1:0] base,
                                          input logic [QW-1:0]        qv);
        logic signed [PJW-1:0] prod;
        prod = PJW'(slope) * PJW'(signed'({1'b0, qv}));
        return MW'(prod + PJW'(base));
    endfunction

    function automatic logic [VW-1:0] cue_clamp(input logic signed [MW-1:0] m);
        logic signed [MW-1:0] s;
        s = m >>> FRAC;
        if (s < 0)            return '0;
        else if (s > IR0_MAX) return VW'(IR0_MAX);
        else                  return VW'(s);
    endfunction

    logic [VSL-1:0]         vsel;
    logic [DIM*MW-1:0]      mac_c;
    logic [DIM-1:0][VW-1:0] ir_c;
    logic [VW-1:0]          z_c;
    logic                   div_start;
    logic                   div_done;
    logic [QW-1:0]          div_quo;
    logic                   last_v;
    logic [MW-1:0]          mac0_c;

    assign vsel = vtx_i[r_q.vidx * VSL +: VSL];

    ppu_xform #(.VW(VW), .MW(MW), .FRAC(FRAC), .DIM(DIM)) u_xform (
        .rot_i   (rot_i),
        .vec_i   (vsel),
        .trans_i (trans_i),
        .mac_o   (mac_c)
    );

    for (genvar i = 0; i < DIM; i++) begin : g_sat
        assign ir_c[i] = sat_ir(signed'(mac_c[i*MW +: MW]));
    end
    assign z_c = clamp_z(signed'(mac_c[(DIM-1)*MW +: MW]));

    assign div_start = (r_q.st == ST_XFORM);

    ppu_divider #(.NW(VW), .QW(QW)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (div_start),
        .num_i   (hdist_i),
        .den_i   (z_c),
        .done_o  (div_done),
        .quo_o   (div_quo)
    );

    assign last_v = !r_q.trip || (r_q.vidx == 2'(DIM-1));
    assign mac0_c = cue(signed'(dqa_i), signed'(dqb_i), r_q.wq);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.busy = 1'b1;
                    r_d.trip = triple_i;
                    r_d.vidx = '0;
                    r_d.st   = ST_XFORM;
                end
            end
            ST_XFORM: begin
                for (int i = 0; i < DIM; i++) begin
                    r_d.wmac[i] = mac_c[i*MW +: MW];
                    r_d.wir[i]  = ir_c[i];
                end
                r_d.wz[r_q.vidx] = z_c;
                r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (div_done) begin
                    r_d.wq = div_quo;
                    r_d.st = ST_PROJ;
                end
            end
            ST_PROJ: begin
                r_d.wxy[r_q.vidx] = {project(signed'(ofy_i), signed'(r_q.wir[1]), r_q.wq),
                                     project(signed'(ofx_i), signed'(r_q.wir[0]), r_q.wq)};
                if (last_v) begin
                    r_d.st = ST_FIN;
                end else begin
                    r_d.vidx = r_q.vidx + 1'b1;
                    r_d.st   = ST_XFORM;
                end
            end
            ST_FIN: begin
                r_d.mac0 = mac0_c;
                r_d.ir0  = cue_clamp(signed'(mac0_c));
                r_d.mac  = r_q.wmac;
                r_d.ir   = r_q.wir;
                if (r_q.trip) begin
                    r_d.sz[0] = r_q.sz[DIM];
                    for (int i = 0; i < DIM; i++) begin
                        r_d.sz[i+1] = r_q.wz[i];
                        r_d.sxy[i]  = r_q.wxy[i];
                    end
                end else begin
                    for (int i = 0; i < DIM; i++) begin
                        r_d.sz[i] = r_q.sz[i+1];
                    end
                    r_d.sz[DIM] = r_q.wz[0];
                    for (int i = 0; i < DIM-1; i++) begin
                        r_d.sxy[i] = r_q.sxy[i+1];
                    end
                    r_d.sxy[DIM-1] = r_q.wxy[0];
                end
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy_o = r_q.busy;
    assign done_o = r_q.done;
    assign mac0_o = r_q.mac0;
    assign mac1_o = r_q.mac[0];
    assign mac2_o = r_q.mac[1];
    assign mac3_o = r_q.mac[2];
    assign ir0_o  = r_q.ir0;
    assign ir1_o  = r_q.ir[0];
    assign ir2_o  = r_q.ir[1];
    assign ir3_o  = r_q.ir[2];
    assign sxy0_o = r_q.sxy[0];
    assign sxy1_o = r_q.sxy[1];
    assign sxy2_o = r_q.sxy[2];
    assign sz0_o  = r_q.sz[0];
    assign sz1_o  = r_q.sz[1];
    assign sz2_o  = r_q.sz[2];
    assign sz3_o  = r_q.sz[3];

    // R9: completion never coincides with busy, and lasts a single cycle
    assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: results only move on the edge that leaves the commit state
    assert_results_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_FIN) |=> ($stable(sz3_o) && $stable(sxy2_o) && $stable(mac0_o) && $stable(ir1_o)));

    // R10: a start seen while busy does not restart the vertex sequence
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && r_q.st == ST_WAIT) |=> (r_q.st == ST_WAIT || r_q.st == ST_PROJ));

    // R7: depth-cue clamp stays within 0..4096
    assert_ir0_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ir0_o <= VW'(IR0_MAX));

    // R5: newest screen x stays inside the signed screen range
    assert_sx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(signed'(sxy2_o[VW-1:0])) <= (2**(SCR-1)) - 1) &&
        (int'(signed'(sxy2_o[VW-1:0])) >= -(2**(SCR-1))));

    // R3: a single-vertex commit moves the previous newest depth down one slot
    assert_sz_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !r_q.trip) |-> (sz2_o == $past(sz3_o)));

    // R8: a triple commit moves the previous newest depth to the oldest slot
    assert_sz_triple_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && r_q.trip) |-> (sz0_o == $past(sz3_o)));
endmodule

// File: tb/tb_persp_proj_unit.sv
`timescale 1ns/1ps
module tb_persp_proj_unit;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          triple_i = 1'b0;
    logic [143:0]  vtx_i = '0;
    logic [143:0]  rot_i = '0;
    logic [95:0]   trans_i = '0;
    logic [31:0]   ofx_i = '0, ofy_i = '0, dqb_i = '0;
    logic [15:0]   hdist_i = '0, dqa_i = '0;
    logic          busy_o, done_o;
    logic [31:0]   mac0_o, mac1_o, mac2_o, mac3_o;
    logic [15:0]   ir0_o, ir1_o, ir2_o, ir3_o;
    logic [31:0]   sxy0_o, sxy1_o, sxy2_o;
    logic [15:0]   sz0_o, sz1_o, sz2_o, sz3_o;

    int     checks = 0;
    int     errors = 0;
    int     cyc = 0;
    longint m_sz [4];
    longint m_sxy [3];

    persp_proj_unit dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .triple_i(triple_i),
        .vtx_i(vtx_i), .rot_i(rot_i), .trans_i(trans_i), .ofx_i(ofx_i), .ofy_i(ofy_i),
        .hdist_i(hdist_i), .dqa_i(dqa_i), .dqb_i(dqb_i),
        .busy_o(busy_o), .done_o(done_o),
        .mac0_o(mac0_o), .mac1_o(mac1_o), .mac2_o(mac2_o), .mac3_o(mac3_o),
        .ir0_o(ir0_o), .ir1_o(ir1_o), .ir2_o(ir2_o), .ir3_o(ir3_o),
        .sxy0_o(sxy0_o), .sxy1_o(sxy1_o), .sxy2_o(sxy2_o),
        .sz0_o(sz0_o), .sz1_o(sz1_o), .sz2_o(sz2_o), .sz3_o(sz3_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint wrap32(input longint x);
        int t;
        t = int'(x);
        return longint'(t);
    endfunction

    function automatic longint clip(input longint x, input longint lo, input longint hi);
        if (x < lo) return lo;
        if (x > hi) return hi;
        return x;
    endfunction

    function automatic longint rot_el(input int r, input int c);
        return longint'($signed(rot_i[(3*r+c)*16 +: 16]));
    endfunction

    function automatic longint vtx_el(input int v, input int c);
        return longint'($signed(vtx_i[(3*v+c)*16 +: 16]));
    endfunction

    function automatic longint tr_el(input int r);
        return longint'($signed(trans_i[r*32 +: 32]));
    endfunction

    task automatic model_and_check(input bit trip);
        longint lm [3];
        longint lir [3];
        longint q = 0;
        longint mac0, ir0;
        int nv;
        nv = trip ? 3 : 1;
        for (int v = 0; v < nv; v++) begin
            longint z, h, sx, sy;
            for (int r = 0; r < 3; r++) begin
                longint acc = 0;
                for (int c = 0; c < 3; c++) acc += rot_el(r, c) * vtx_el(v, c);
                lm[r]  = wrap32(tr_el(r) + (acc >>> 12));
                lir[r] = clip(lm[r], -32768, 32767);
            end
            z = clip(lm[2], 0, 65535);
            h = longint'(hdist_i);
            q = (h >= 2*z) ? 64'h1FFFF : (h <<< 16) / z;
            sx = clip((longint'($signed(ofx_i)) + lir[0]*q) >>> 16, -1024, 1023);
            sy = clip((longint'($signed(ofy_i)) + lir[1]*q) >>> 16, -1024, 1023);
            for (int i = 0; i < 3; i++) m_sz[i] = m_sz[i+1];
            m_sz[3] = z;
            m_sxy[0] = m_sxy[1];
            m_sxy[1] = m_sxy[2];
            m_sxy[2] = ((sy & 64'hFFFF) << 16) | (sx & 64'hFFFF);
        end
        mac0 = wrap32(longint'($signed(dqb_i)) + longint'($signed(dqa_i)) * q);
        ir0  = clip(mac0 >>> 12, 0, 4096);
        chk("R1", "mac1", longint'($signed(mac1_o)), lm[0]);
        chk("R1", "mac2", longint'($signed(mac2_o)), lm[1]);
        chk("R1", "mac3", longint'($signed(mac3_o)), lm[2]);
        chk("R2", "ir1", longint'($signed(ir1_o)), lir[0]);
        chk("R2", "ir2", longint'($signed(ir2_o)), lir[1]);
        chk("R2", "ir3", longint'($signed(ir3_o)), lir[2]);
        chk(trip ? "R8" : "R3", "sz0", longint'(sz0_o), m_sz[0]);
        chk(trip ? "R8" : "R3", "sz1", longint'(sz1_o), m_sz[1]);
        chk(trip ? "R8" : "R3", "sz2", longint'(sz2_o), m_sz[2]);
        chk(trip ? "R8" : "R3", "sz3", longint'(sz3_o), m_sz[3]);
        chk(trip ? "R8" : "R6", "sxy0", longint'(sxy0_o), m_sxy[0]);
        chk(trip ? "R8" : "R6", "sxy1", longint'(sxy1_o), m_sxy[1]);
        chk("R5", "sxy2", longint'(sxy2_o), m_sxy[2]);
        chk("R7", "mac0", longint'($signed(mac0_o)), mac0);
        chk("R7", "ir0", longint'(ir0_o), ir0);
    endtask

    task automatic run_op(input bit trip, input bit poke);
        bit held = 1'b1;
        int n = 0;
        @(negedge clk);
        triple_i = trip;
        start_i  = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R9", "busy after start", longint'(busy_o), 1);
        while (!done_o && n < 500) begin
            if (longint'(sz3_o) != m_sz[3] || longint'(sxy2_o) != m_sxy[2]) held = 1'b0;
            start_i = poke && (n == 3 || n == 12);
            @(negedge clk);
            n++;
        end
        start_i = 1'b0;
        chk("R9", "outputs held while busy", longint'(held), 1);
        if (!done_o) begin
            errors++;
            $display("FAIL R9 no completion actual=0 expected=1");
            return;
        end
        model_and_check(trip);
        chk("R9", "busy low at done", longint'(busy_o), 0);
        @(negedge clk);
        chk("R9", "done is one cycle", longint'(done_o), 0);
    endtask

    task automatic set_matrix(input int mi);
        for (int r = 0; r < 3; r++) begin
            for (int c = 0; c < 3; c++) begin
                int e;
                case (mi)
                    0: e = (r == c) ? 4096 : 0;
                    1: e = (r*3 + c) * 733 - 2900;
                    default: e = ((r + c) % 2 == 1) ? -32768 : 32767;
                endcase
                rot_i[(3*r+c)*16 +: 16] = 16'(e);
            end
        end
        case (mi)
            0: begin
                trans_i = {32'sd0, 32'sd0, 32'sd0};
                ofx_i = 32'h00A0_0000; ofy_i = 32'h0078_0000;
                dqa_i = 16'h0100; dqb_i = 32'h0100_0000;
            end
            1: begin
                trans_i = {32'sh0000_4000, -32'sd200, 32'sd100};
                ofx_i = -32'sh0050_0000; ofy_i = 32'sh0030_0000;
                dqa_i = 16'hE000; dqb_i = 32'h0;
            end
            default: begin
                trans_i = {32'sh0001_0000, -32'sh7FFF_0000, 32'sh7FFF_0000};
                ofx_i = 32'h7FFF_0000; ofy_i = -32'sh7FFF_0000;
                dqa_i = 16'h7FFF; dqb_i = 32'h0050_0000;
            end
        endcase
    endtask

    task automatic directed_div(input longint z, input longint h);
        set_matrix(0);
        trans_i = {32'(z), 32'sd0, 32'sd0};
        vtx_i = '0;
        hdist_i = 16'(h);
        dqa_i = 16'd1;
        dqb_i = 32'd0;
        ofx_i = 32'd0;
        ofy_i = 32'd0;
        run_op(1'b0, 1'b0);
        chk("R4", "factor via mac0", longint'($signed(mac0_o)),
            (h >= 2*z) ? 64'h1FFFF : (h <<< 16) / z);
    endtask

    initial begin
        int vals [8] = '{0, 1, -1, 100, -1000, 32767, -32768, 3000};
        int hv [4] = '{0, 200, 16384, 65535};
        for (int i = 0; i < 4; i++) m_sz[i] = 0;
        for (int i = 0; i < 3; i++) m_sxy[i] = 0;

        repeat (3) @(negedge clk);
        chk("R11", "busy in reset", longint'(busy_o), 0);
        chk("R11", "done in reset", longint'(done_o), 0);
        chk("R11", "mac0 in reset", longint'(mac0_o), 0);
        chk("R11", "ir0 in reset", longint'(ir0_o), 0);
        chk("R11", "sz3 in reset", longint'(sz3_o), 0);
        chk("R11", "sxy2 in reset", longint'(sxy2_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int mi = 0; mi < 3; mi++) begin
            for (int zi = 0; zi < 8; zi++) begin
                for (int hi = 0; hi < 4; hi++) begin
                    set_matrix(mi);
                    for (int v = 0; v < 3; v++) begin
                        vtx_i[(3*v+0)*16 +: 16] = 16'(vals[(zi+v+1)%8]);
                        vtx_i[(3*v+1)*16 +: 16] = 16'(vals[(zi+2*v+5)%8]);
                        vtx_i[(3*v+2)*16 +: 16] = 16'(vals[(zi+v)%8]);
                    end
                    hdist_i = 16'(hv[hi]);
                    run_op(((zi + hi) % 2) == 1, 1'b0);
                end
            end
        end

        directed_div(100, 200);
        directed_div(100, 199);
        directed_div(0, 0);
        directed_div(0, 5000);
        directed_div(1, 1);
        directed_div(65535, 65534);
        directed_div(30000, 59999);

        // R10: start pulses mid-operation must not trigger a second commit
        set_matrix(1);
        vtx_i[0 +: 48] = {16'sd700, -16'sd300, 16'sd1200};
        hdist_i = 16'd900;
        run_op(1'b0, 1'b1);
        begin
            bit extra = 1'b0;
            for (int k = 0; k < 60; k++) begin
                @(negedge clk);
                if (done_o || busy_o) extra = 1'b1;
            end
            chk("R10", "no second operation", longint'(extra), 0);
            chk("R10", "no extra depth shift", longint'(sz3_o), m_sz[3]);
            chk("R10", "no extra point shift", longint'(sxy1_o), m_sxy[1]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule